// File: doc/BRIEF.md
# Squared-Excess Overload Trip Controller

This block is the digital protection logic for a single power-switch channel. It behaves like a slow-blow fuse. Each load-current sample above a programmable rated level adds the square of the excess, times a programmable gain, to an accumulator. The switch opens when the accumulator reaches a fixed 4096 units, so the trip time falls with the square of the overload. Samples at or below the rated level drain the accumulator at a fixed rate, so a short inrush is forgotten. The block is sized for one channel; a chip with four channels places four copies.

After a trip the channel waits a restart delay, set in clock cycles, and then closes the switch again. Each automatic restart adds one to a retry counter. A trip that happens with the counter already at its limit latches the channel off. The channel then stays off until the on/off command is dropped and raised again. A fast over-current input opens the switch without waiting for the integral. An over-temperature condition forces the channel off from any state. That condition has hysteresis, with separate assert and release inputs. The sensing front end, the gate driver and the thermal sensors are outside the block.

Top module: `fuse_trip_ctrl`

## Requirements
- R1: After reset, state_o is OFF (0), and sw_en_o, fault_o, trip_flag_o and retry_cnt_o are all zero.
- R2: The states are encoded OFF=0, ON=1, TRIPPED_WAIT=2, LATCHED_OFF=3, THERMAL_OFF=4. From OFF, with on_cmd_i high and no over-temperature, the channel enters ON at the next clock edge. From ON, with on_cmd_i low, it enters OFF at the next edge. sw_en_o is high exactly when state_o is ON.
- R3: On each cur_vld_i sample taken while ON, the accumulator grows by e*e*gain_i, where e = cur_code_i - rated_i when the current is above the rated level. The accumulator starts from zero on entry to ON. The state leaves ON at the second clock edge after the sample that brings the accumulator to 4096.
- R4: Both the per-sample increment and the accumulator saturate at 4096 and never wrap. A single very large excess therefore trips after exactly one sample.
- R5: A sample with cur_code_i at or below rated_i never trips the channel. Such a sample lowers the accumulator by BLEED, with a floor at zero.
- R6: A trip with the retry count below MAX_RETRY enters TRIPPED_WAIT. The channel stays there for exactly RESTART_CYC cycles, then returns to ON, and retry_cnt_o rises by one.
- R7: A trip with the retry count equal to MAX_RETRY enters LATCHED_OFF. The channel stays there while on_cmd_i is high and goes to OFF at the edge after on_cmd_i is low.
- R8: ocp_fault_i high while ON trips the channel at the next edge, independent of the accumulator.
- R9: ot_assert_i moves any state to THERMAL_OFF at the next edge. The channel stays there after ot_assert_i falls, until ot_release_i is seen, and then goes to OFF.
- R10: trip_flag_o is set by every trip and stays set. trip_flag_o and retry_cnt_o are cleared at the edge after on_cmd_i is low. fault_o is high exactly in TRIPPED_WAIT, LATCHED_OFF and THERMAL_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_cmd_i | input | 1 | On/off command for the channel |
| cur_vld_i | input | 1 | Qualifies a new load-current sample |
| cur_code_i | input | CUR_W | Sampled load-current code |
| rated_i | input | CUR_W | Rated current level (offset removed before squaring) |
| gain_i | input | GAIN_W | Gain applied to the squared excess |
| ocp_fault_i | input | 1 | Fast over-current / over-power fault |
| ot_assert_i | input | 1 | Over-temperature assert threshold crossed |
| ot_release_i | input | 1 | Over-temperature release threshold crossed |
| sw_en_o | output | 1 | Power switch enable |
| state_o | output | 3 | Channel state code |
| fault_o | output | 1 | Channel held off by a fault |
| trip_flag_o | output | 1 | Sticky trip indication |
| retry_cnt_o | output | RETRY_W | Automatic restarts since the last off command |

## Verification
A wrong accumulator value shows up only through the moment the switch opens. The bench therefore measures, to the cycle, how long sw_en_o stays high for several excess and gain pairs. A partial bleed-down before a second overload exposes a wrong drain rate within tens of cycles. A restart timer that is off by one changes the TRIPPED_WAIT dwell that the bench counts at state_o. A wrong retry count either latches one trip early or late, or shows a wrong retry_cnt_o on the first cycle back in ON. Fault, thermal and off-command paths are checked one edge after their stimulus.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ON    = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LATCH = 3'd3,
    ST_THERM = 3'd4
  } fuse_state_e;
endpackage

// File: rtl/fuse_i2t_accum.sv
// Squared-excess integrator with saturation and idle bleed.
module fuse_i2t_accum #(
  parameter int CUR_W  = 10,
  parameter int GAIN_W = 4,
  parameter int ACC_W  = 12,
  parameter int BLEED  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              smp_vld_i,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [CUR_W-1:0]  rated_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              full_o
);
  localparam int PROD_W = 2 * CUR_W + GAIN_W;
  localparam logic [ACC_W:0] FULL = {1'b1, {ACC_W{1'b0}}};

  logic [ACC_W:0]   acc_q;
  logic [CUR_W-1:0] excess;
  logic [PROD_W-1:0] prod;
  logic [ACC_W:0]   step;
  logic [ACC_W+1:0] sum;
  logic [ACC_W:0]   acc_up;
  logic [ACC_W:0]   acc_down;

  always_comb begin
    excess = (cur_i > rated_i) ? (cur_i - rated_i) : '0;
    prod   = PROD_W'(excess) * PROD_W'(excess) * PROD_W'(gain_i);
    step   = (prod >= PROD_W'(FULL)) ? FULL : prod[ACC_W:0];
    sum    = {1'b0, acc_q} + {1'b0, step};
    acc_up = (sum >= {1'b0, FULL}) ? FULL : sum[ACC_W:0];
  end

  generate
    if (BLEED == 0) begin : g_no_bleed
      assign acc_down = acc_q;
    end else begin : g_bleed
      assign acc_down = (acc_q > (ACC_W+1)'(BLEED)) ? (acc_q - (ACC_W+1)'(BLEED)) : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      acc_q <= '0;
    end else if (smp_vld_i) begin
      acc_q <= (excess != '0) ? acc_up : acc_down;
    end
  end

  assign full_o = (acc_q == FULL);
endmodule

// File: rtl/fuse_restart_timer.sv
// Counts the cool-down interval while run_i is held.
module fuse_restart_timer #(
  parameter int RESTART_CYC = 500_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(RESTART_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(RESTART_CYC - 1));
endmodule

// File: rtl/fuse_chan_fsm.sv
// Channel sequencing: on/off, trip, restart, latch-off, thermal hold.
module fuse_chan_fsm
  import fuse_pkg::*;
#(
  parameter int MAX_RETRY = 4096,
  parameter int RETRY_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               on_cmd_i,
  input  logic               full_i,
  input  logic               ocp_i,
  input  logic               ot_set_i,
  input  logic               ot_clr_i,
  input  logic               restart_done_i,
  output fuse_state_e        state_o,
  output logic               sw_en_o,
  output logic               fault_o,
  output logic               trip_flag_o,
  output logic [RETRY_W-1:0] retry_cnt_o,
  output logic               acc_en_o,
  output logic               timer_run_o
);
  fuse_state_e        state_q, state_d;
  logic               hot_q, hot_d;
  logic               trip;
  logic               sw_en_q, fault_q, flag_q;
  logic [RETRY_W-1:0] retry_q;

  always_comb begin
    hot_d   = ot_set_i | (hot_q & ~ot_clr_i);
    trip    = 1'b0;
    state_d = state_q;
    if (hot_d) begin
      state_d = ST_THERM;
    end else begin
      case (state_q)
        ST_OFF:   if (on_cmd_i) state_d = ST_ON;
        ST_ON: begin
          if (!on_cmd_i) begin
            state_d = ST_OFF;
          end else if (ocp_i || full_i) begin
            trip    = 1'b1;
            state_d = (retry_q >= RETRY_W'(MAX_RETRY)) ? ST_LATCH : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!on_cmd_i)           state_d = ST_OFF;
          else if (restart_done_i) state_d = ST_ON;
        end
        ST_LATCH: if (!on_cmd_i) state_d = ST_OFF;
        ST_THERM: state_d = ST_OFF;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      hot_q   <= 1'b0;
      sw_en_q <= 1'b0;
      fault_q <= 1'b0;
      flag_q  <= 1'b0;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      hot_q   <= hot_d;
      sw_en_q <= (state_d == ST_ON);
      fault_q <= (state_d == ST_WAIT) || (state_d == ST_LATCH) || (state_d == ST_THERM);
      if (!on_cmd_i)   flag_q <= 1'b0;
      else if (trip)   flag_q <= 1'b1;
      if (!on_cmd_i)
        retry_q <= '0;
      else if (state_q == ST_WAIT && state_d == ST_ON)
        retry_q <= retry_q + 1'b1;
    end
  end

  assign state_o     = state_q;
  assign sw_en_o     = sw_en_q;
  assign fault_o     = fault_q;
  assign trip_flag_o = flag_q;
  assign retry_cnt_o = retry_q;
  assign acc_en_o    = (state_q == ST_ON);
  assign timer_run_o = (state_q == ST_WAIT);
endmodule

// File: rtl/fuse_trip_ctrl.sv
// Top: one protected switch channel.
module fuse_trip_ctrl
  import fuse_pkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int GAIN_W      = 4,
  parameter int ACC_W       = 12,
  parameter int BLEED       = 1,
  parameter int RESTART_CYC = 500_000_000,
  parameter int MAX_RETRY   = 4096,
  localparam int RETRY_W    = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               on_cmd_i,
  input  logic               cur_vld_i,
  input  logic [CUR_W-1:0]   cur_code_i,
  input  logic [CUR_W-1:0]   rated_i,
  input  logic [GAIN_W-1:0]  gain_i,
  input  logic               ocp_fault_i,
  input  logic               ot_assert_i,
  input  logic               ot_release_i,
  output logic               sw_en_o,
  output logic [2:0]         state_o,
  output logic               fault_o,
  output logic               trip_flag_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  logic        acc_en, acc_full, timer_run, timer_done;
  fuse_state_e st;

  fuse_i2t_accum #(
    .CUR_W(CUR_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W), .BLEED(BLEED)
  ) accum_i (
    .clk(clk), .rst(rst), .en_i(acc_en), .smp_vld_i(cur_vld_i),
    .cur_i(cur_code_i), .rated_i(rated_i), .gain_i(gain_i), .full_o(acc_full)
  );

  fuse_restart_timer #(
    .RESTART_CYC(RESTART_CYC)
  ) timer_i (
    .clk(clk), .rst(rst), .run_i(timer_run), .done_o(timer_done)
  );

  fuse_chan_fsm #(
    .MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .on_cmd_i(on_cmd_i), .full_i(acc_full),
    .ocp_i(ocp_fault_i), .ot_set_i(ot_assert_i), .ot_clr_i(ot_release_i),
    .restart_done_i(timer_done), .state_o(st), .sw_en_o(sw_en_o),
    .fault_o(fault_o), .trip_flag_o(trip_flag_o), .retry_cnt_o(retry_cnt_o),
    .acc_en_o(acc_en), .timer_run_o(timer_run)
  );

  assign state_o = st;
endmodule

// File: rtl/fuse_trip_ctrl_chk.sv
module fuse_trip_ctrl_chk #(
  parameter int RETRY_W   = 13,
  parameter int MAX_RETRY = 4096
) (
  input logic               clk,
  input logic               rst,
  input logic               on_cmd_i,
  input logic               ocp_fault_i,
  input logic               ot_assert_i,
  input logic               sw_en_o,
  input logic [2:0]         state_o,
  input logic               fault_o,
  input logic               trip_flag_o,
  input logic [RETRY_W-1:0] retry_cnt_o
);
  // R2
  sw_en_state_chk: assert property (@(posedge clk) disable iff (rst)
    sw_en_o == (state_o == 3'd1));

  // R8
  ocp_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && ocp_fault_i) |=> (state_o != 3'd1));

  // R9
  thermal_force_chk: assert property (@(posedge clk) disable iff (rst)
    ot_assert_i |=> (state_o == 3'd4));

  // R10
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !on_cmd_i |=> (!trip_flag_o && retry_cnt_o == '0));

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    retry_cnt_o <= RETRY_W'(MAX_RETRY));

  // R6
  restart_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && $past(state_o) == 3'd2) |-> (retry_cnt_o == $past(retry_cnt_o) + 1'b1));

  // R10
  fault_state_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o == (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4));
endmodule

bind fuse_trip_ctrl fuse_trip_ctrl_chk #(
  .RETRY_W(RETRY_W), .MAX_RETRY(MAX_RETRY)
) chk_i (
  .clk(clk), .rst(rst), .on_cmd_i(on_cmd_i), .ocp_fault_i(ocp_fault_i),
  .ot_assert_i(ot_assert_i), .sw_en_o(sw_en_o), .state_o(state_o),
  .fault_o(fault_o), .trip_flag_o(trip_flag_o), .retry_cnt_o(retry_cnt_o)
);

// File: tb/fuse_trip_ctrl_tb_top.sv
module fuse_trip_ctrl_tb_top;
  localparam int CUR_W = 8, GAIN_W = 4, BLEED = 4, RESTART = 20, MAXR = 2;
  localparam int RW = $clog2(MAXR + 1);
  localparam int RATED = 100;

  logic clk = 1'b0, rst = 1'b1;
  logic on_cmd = 0, vld = 1, ocp = 0, ot_a = 0, ot_r = 0;
  logic [CUR_W-1:0]  cur = RATED[CUR_W-1:0], rated = RATED[CUR_W-1:0];
  logic [GAIN_W-1:0] gain = 1;
  logic sw_en, fault, flag;
  logic [2:0] state;
  logic [RW-1:0] retry;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  fuse_trip_ctrl #(
    .CUR_W(CUR_W), .GAIN_W(GAIN_W), .ACC_W(12), .BLEED(BLEED),
    .RESTART_CYC(RESTART), .MAX_RETRY(MAXR)
  ) dut_i (
    .clk(clk), .rst(rst), .on_cmd_i(on_cmd), .cur_vld_i(vld), .cur_code_i(cur),
    .rated_i(rated), .gain_i(gain), .ocp_fault_i(ocp), .ot_assert_i(ot_a),
    .ot_release_i(ot_r), .sw_en_o(sw_en), .state_o(state), .fault_o(fault),
    .trip_flag_o(flag), .retry_cnt_o(retry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_on(output int n);
    n = 0;
    while (sw_en && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic count_state(input logic [2:0] s, output int n);
    n = 0;
    while (state == s && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic go_off();
    on_cmd = 0; ocp = 0; cur = rated; gain = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 sw_en", sw_en, 0);
    chk("R1 fault", fault, 0);
    chk("R1 flag", flag, 0);
    chk("R1 retry", retry, 0);
  endtask

  task automatic t_onoff();
    go_off();
    on_cmd = 1;
    @(negedge clk);
    chk("R2 on state", state, 1);
    chk("R2 sw_en on", sw_en, 1);
    repeat (700) @(negedge clk);
    chk("R5 no trip at rated", state, 1);
    on_cmd = 0;
    @(negedge clk);
    chk("R2 off state", state, 0);
    chk("R2 sw_en off", sw_en, 0);
  endtask

  task automatic trip_from_on(input int r, input int e, input int g, input int exp, input string req);
    int n;
    go_off();
    rated = r[CUR_W-1:0];
    cur = CUR_W'(r + e); gain = g[GAIN_W-1:0]; on_cmd = 1;
    @(negedge clk);
    count_on(n);
    chk(req, n, exp);
    chk("R6 enters wait", state, 2);
    chk("R10 flag set", flag, 1);
    chk("R10 fault in wait", fault, 1);
    rated = RATED[CUR_W-1:0];
  endtask

  task automatic t_curve();
    trip_from_on(100, 16, 1, 17, "R3 e16 g1");
    trip_from_on(100, 8, 2, 33, "R3 e8 g2");
    trip_from_on(100, 3, 1, 457, "R3 e3 g1");
    trip_from_on(200, 10, 4, 12, "R3 rated200 e10 g4");
    trip_from_on(100, 64, 1, 2, "R4 step saturates");
    trip_from_on(100, 155, 15, 2, "R4 no wrap large excess");
  endtask

  task automatic t_bleed();
    int n;
    go_off();
    on_cmd = 1;
    @(negedge clk);
    cur = RATED + 16;
    repeat (10) @(negedge clk);
    cur = RATED;
    repeat (64) @(negedge clk);
    cur = RATED + 16;
    @(negedge clk);
    count_on(n);
    chk("R5 partial bleed", n, 7);
  endtask

  task automatic t_restart_latch();
    int n;
    go_off();
    cur = RATED + 64; on_cmd = 1;
    @(negedge clk);
    count_on(n);
    chk("R6 first trip", n, 2);
    count_state(3'd2, n);
    chk("R6 wait length", n, RESTART);
    chk("R6 back on", state, 1);
    chk("R6 retry 1", retry, 1);
    count_on(n);
    count_state(3'd2, n);
    chk("R6 retry 2", retry, 2);
    count_on(n);
    chk("R7 latched", state, 3);
    repeat (100) @(negedge clk);
    chk("R7 stays latched", state, 3);
    chk("R7 sw_en low", sw_en, 0);
    chk("R10 flag sticky", flag, 1);
    chk("R10 retry held", retry, 2);
    on_cmd = 0;
    @(negedge clk);
    chk("R7 off releases", state, 0);
    chk("R10 flag cleared", flag, 0);
    chk("R10 retry cleared", retry, 0);
    cur = RATED; on_cmd = 1;
    @(negedge clk);
    chk("R7 on again", state, 1);
  endtask

  task automatic t_ocp();
    go_off();
    on_cmd = 1;
    repeat (2) @(negedge clk);
    ocp = 1;
    @(negedge clk);
    ocp = 0;
    chk("R8 ocp trips", state, 2);
    chk("R8 sw_en low", sw_en, 0);
    chk("R8 flag", flag, 1);
  endtask

  task automatic t_thermal();
    go_off();
    on_cmd = 1;
    repeat (2) @(negedge clk);
    ot_a = 1;
    @(negedge clk);
    ot_a = 0;
    chk("R9 thermal off", state, 4);
    chk("R9 fault", fault, 1);
    repeat (30) @(negedge clk);
    chk("R9 hysteresis hold", state, 4);
    ot_r = 1;
    @(negedge clk);
    ot_r = 0;
    chk("R9 release to off", state, 0);
    @(negedge clk);
    chk("R9 then on", state, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_onoff();
    t_curve();
    t_bleed();
    t_restart_latch();
    t_ocp();
    t_thermal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule